// File: doc/BRIEF.md
# ALU Status and Control Flag Register

This block turns the outcome of an ALU operation into the processor's status flags and holds them. For each accepted update it reads operand A, operand B, the result, and the ALU's carry-out. It also reads an operation class (add, subtract or logic) and a width select for 8-bit or 16-bit operations. From these it registers carry, parity, auxiliary (nibble) carry, zero, sign and overflow.

Three control flags sit beside the status flags: single-step (trap), interrupt enable and string direction. Each changes only through explicit set and clear pulses. The block exports every flag as one word. It also gates the maskable interrupt request with the interrupt-enable flag and passes the non-maskable request through without any gating.

The update input is a valid/ready stream. `upd_ready` is held high at all times, so the block never applies back-pressure: each cycle with `upd_valid` high is one accepted update, and its flags appear in `flags_o` after the next rising clock edge.

Top module: `alu_flag_reg`

## Requirements
- R1: While `rst_n` is low, all nine flags are 0 and `irq_accept` is 0.
- R2: `flags_o` bit layout: 0 carry, 1 parity, 2 auxiliary, 3 zero, 4 sign, 5 overflow, 6 trap, 7 interrupt enable, 8 direction.
- R3: On an accepted add (`op_kind`=00) or subtract (01), carry takes `alu_cout` in the cycle after acceptance.
- R4: Parity is 1 when bits 7:0 of the result hold an even number of ones, for both 8-bit and 16-bit operations.
- R5: For add and subtract, auxiliary is set on a carry or borrow out of bit 3 (bit 4 of A^B^result). A logic operation (10) leaves auxiliary unchanged.
- R6: Zero is 1 when the result is all zeros and sign copies the top bit. Both are taken over bits 7:0 when `width_wide`=0 and over all 16 bits when `width_wide`=1.
- R7: Overflow on add is set when A and B share a sign that differs from the result's sign. On subtract it is set when the signs of A and B differ and the result's sign differs from A's sign.
- R8: A logic operation clears carry and overflow.
- R9: A cycle without `upd_valid`, or with `op_kind`=11, leaves all six status flags unchanged.
- R10: `ctl_set` and `ctl_clr` bits (0 trap, 1 interrupt enable, 2 direction) set or clear the flag in the next cycle. Set wins when both are raised. Status updates never change the control flags.
- R11: `irq_accept` is `irq_req` gated by interrupt enable, and `nmi_accept` always follows `nmi_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Status update offered |
| upd_ready | output | 1 | Always 1: updates never stall |
| opnd_a | input | 16 | ALU operand A |
| opnd_b | input | 16 | ALU operand B |
| alu_res | input | 16 | ALU result |
| alu_cout | input | 1 | ALU carry-out or borrow at the selected width |
| op_kind | input | 2 | 00 add, 01 subtract, 10 logic, 11 no status change |
| width_wide | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| ctl_set | input | 3 | Set pulses for trap, interrupt enable, direction |
| ctl_clr | input | 3 | Clear pulses for trap, interrupt enable, direction |
| irq_req | input | 1 | Maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| flags_o | output | 9 | Flag word, layout in R2 |
| irq_accept | output | 1 | Maskable request accepted |
| nmi_accept | output | 1 | Non-maskable request accepted |

## Verification
The bench builds the block with its default parameters: 16-bit data, an 8-bit narrow width and a 4-bit nibble. These values put both width selects within reach, so the bench can drive 8-bit results with nonzero upper bits to show that zero, sign and parity ignore them. The 16-bit case makes it possible to distinguish low-byte parity from full-width zero, for example on a result of 0x0100. The cases include signed overflow at 0x7F+1, 0x80-1 and 0x8000+0x8000, and a borrow through the nibble boundary in 0-1.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  typedef enum logic [1:0] {
    OP_ADD   = 2'b00,
    OP_SUB   = 2'b01,
    OP_LOGIC = 2'b10,
    OP_NONE  = 2'b11
  } op_kind_e;

  // lsb first: carry, parity, aux, zero, sign, overflow
  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } status_t;

  localparam int STATUS_W = $bits(status_t);
  localparam int CTRL_W   = 3;
endpackage

// File: rtl/alu_status_calc.sv
module alu_status_calc
  import alu_flag_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int PAR_W    = 8,
  parameter int NIB_W    = 4
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] res,
  input  logic              cout,
  input  op_kind_e          op,
  input  logic              wide,
  input  status_t           cur,
  output status_t           nxt
);
  localparam int MSB_W = DATA_W - 1;
  localparam int MSB_N = NARROW_W - 1;

  logic a_msb, b_msb, r_msb, zero_v, half_c;
  logic [DATA_W-1:0] xsum;

  always_comb begin
    a_msb  = wide ? a[MSB_W]   : a[MSB_N];
    b_msb  = wide ? b[MSB_W]   : b[MSB_N];
    r_msb  = wide ? res[MSB_W] : res[MSB_N];
    zero_v = wide ? (res == '0) : (res[MSB_N:0] == '0);
    xsum   = a ^ b ^ res;
    half_c = xsum[NIB_W];
  end

  always_comb begin
    nxt     = cur;
    nxt.par = ~^res[PAR_W-1:0];
    nxt.zro = zero_v;
    nxt.sgn = r_msb;
    unique case (op)
      OP_ADD: begin
        nxt.cry = cout;
        nxt.aux = half_c;
        nxt.ovf = (a_msb == b_msb) && (r_msb != a_msb);
      end
      OP_SUB: begin
        nxt.cry = cout;
        nxt.aux = half_c;
        nxt.ovf = (a_msb != b_msb) && (r_msb != a_msb);
      end
      OP_LOGIC: begin
        nxt.cry = 1'b0;
        nxt.ovf = 1'b0;
      end
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/ctrl_flag_bank.sv
module ctrl_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)        q[i] <= 1'b0;
      else if (set_i[i]) q[i] <= 1'b1;
      else if (clr_i[i]) q[i] <= 1'b0;
    end

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> q[i]);
    // R10
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !q[i]);
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flag_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int NIB_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              alu_cout,
  input  logic [1:0]        op_kind,
  input  logic              width_wide,
  input  logic [2:0]        ctl_set,
  input  logic [2:0]        ctl_clr,
  input  logic              irq_req,
  input  logic              nmi_req,
  output logic [8:0]        flags_o,
  output logic              irq_accept,
  output logic              nmi_accept
);
  localparam int IE_BIT = 1;

  status_t            st_q, st_d;
  logic [CTRL_W-1:0]  ctl_q;
  op_kind_e           op_e;

  assign upd_ready = 1'b1;
  assign op_e      = op_kind_e'(op_kind);

  alu_status_calc #(
    .DATA_W(DATA_W), .NARROW_W(NARROW_W), .PAR_W(NARROW_W), .NIB_W(NIB_W)
  ) u_calc (
    .a(opnd_a), .b(opnd_b), .res(alu_res), .cout(alu_cout),
    .op(op_e), .wide(width_wide), .cur(st_q), .nxt(st_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                      st_q <= '0;
    else if (upd_valid && upd_ready) st_q <= st_d;
  end

  ctrl_flag_bank #(.N(CTRL_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .set_i(ctl_set), .clr_i(ctl_clr), .q(ctl_q)
  );

  assign flags_o    = {ctl_q, st_q};
  assign irq_accept = irq_req & ctl_q[IE_BIT];
  assign nmi_accept = nmi_req;

  // R8
  logic_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && op_kind == 2'b10) |=> (!flags_o[0] && !flags_o[5]));
  // R5
  logic_keeps_aux_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && op_kind == 2'b10) |=> $stable(flags_o[2]));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_valid || op_kind == 2'b11) |=> $stable(flags_o[5:0]));
  // R10
  ctl_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_set == 3'b000 && ctl_clr == 3'b000) |=> $stable(flags_o[8:6]));
  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_clr[IE_BIT] && !ctl_set[IE_BIT]) |=> !irq_accept);
  // R3
  carry_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && op_kind[1] == 1'b0) |=> (flags_o[0] == $past(alu_cout)));
endmodule

// File: tb/alu_flag_reg_tb.sv
module alu_flag_reg_tb;
  import alu_flag_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_valid = 1'b0;
  logic        upd_ready;
  logic [15:0] opnd_a = '0, opnd_b = '0, alu_res = '0;
  logic        alu_cout = 1'b0;
  logic [1:0]  op_kind = 2'b11;
  logic        width_wide = 1'b0;
  logic [2:0]  ctl_set = '0, ctl_clr = '0;
  logic        irq_req = 1'b0, nmi_req = 1'b0;
  logic [8:0]  flags_o;
  logic        irq_accept, nmi_accept;

  int checks = 0, fails = 0;
  logic [8:0] model = '0;
  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  alu_flag_reg u_dut (.*);

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare one expected word per cycle
  initial forever begin
    @(negedge clk);
    if (exp_q.size() > 0) begin
      logic [8:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(flags_o === e, t, {7'd0, flags_o}, {7'd0, e});
    end
  end

  function automatic int sval(logic [15:0] v, bit wide);
    return wide ? int'($signed(v)) : int'($signed(v[7:0]));
  endfunction

  task automatic do_op(op_kind_e op, bit wide, logic [15:0] a, logic [15:0] b,
                       string tag, bit valid = 1'b1);
    logic [16:0] s;
    logic [15:0] r;
    logic c;
    int si, lim;
    lim = wide ? 32767 : 127;
    case (op)
      OP_ADD:   begin s = {1'b0, a} + {1'b0, b}; r = s[15:0];
                      c = wide ? s[16] : ((a[7:0] + {8'd0, b[7:0]}) > 16'hFF);
                      si = sval(a, wide) + sval(b, wide); end
      OP_SUB:   begin r = a - b;
                      c = wide ? (a < b) : (a[7:0] < b[7:0]);
                      si = sval(a, wide) - sval(b, wide); end
      default:  begin r = a & b; c = 1'b0; si = 0; end
    endcase
    if (valid && op != OP_NONE) begin
      model[1] = ($countones(r[7:0]) % 2) == 0;
      model[3] = wide ? (r == 16'd0) : (r[7:0] == 8'd0);
      model[4] = wide ? r[15] : r[7];
      if (op == OP_LOGIC) begin
        model[0] = 1'b0; model[5] = 1'b0;
      end else begin
        model[0] = c;
        model[5] = (si > lim) || (si < -lim - 1);
        model[2] = (op == OP_ADD) ? ((a[3:0] + {1'b0, b[3:0]}) > 5'd15)
                                  : (a[3:0] < b[3:0]);
      end
    end
    @(negedge clk);
    upd_valid = valid; op_kind = op; width_wide = wide;
    opnd_a = a; opnd_b = b; alu_res = r; alu_cout = c;
    @(posedge clk); #1;
    upd_valid = 1'b0;
    exp_q.push_back(model); tag_q.push_back(tag);
  endtask

  task automatic do_ctl(logic [2:0] s, logic [2:0] k, string tag);
    model[8:6] = (model[8:6] | s) & ~(k & ~s);
    @(negedge clk);
    ctl_set = s; ctl_clr = k;
    @(posedge clk); #1;
    ctl_set = '0; ctl_clr = '0;
    exp_q.push_back(model); tag_q.push_back(tag);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(flags_o == 9'd0, "R1 reset flags", {7'd0, flags_o}, 16'd0);
    check(irq_accept == 1'b0 && upd_ready, "R1 reset irq", {15'd0, irq_accept}, 16'd0);
    rst_n = 1'b1;
    // R7 R5 R2 narrow signed overflow on add
    do_op(OP_ADD, 1'b0, 16'h007F, 16'h0001, "R7 add 7F+1");
    // R3 R6 narrow carry, zero, upper result bits ignored
    do_op(OP_ADD, 1'b0, 16'h12FF, 16'h0001, "R3 R6 add FF+1 narrow");
    // R7 wide add overflow with carry
    do_op(OP_ADD, 1'b1, 16'h8000, 16'h8000, "R7 add 8000+8000");
    // R4 wide result 0100: parity on low byte only, not zero
    do_op(OP_ADD, 1'b1, 16'h00FF, 16'h0001, "R4 parity low byte");
    // R5 borrow through nibble, R3 borrow carry
    do_op(OP_SUB, 1'b1, 16'h0000, 16'h0001, "R5 sub 0-1");
    // R7 narrow subtract overflow
    do_op(OP_SUB, 1'b0, 16'h0080, 16'h0001, "R7 sub 80-1");
    do_op(OP_SUB, 1'b1, 16'h7000, 16'h1000, "R7 sub no ovf");
    // R8 logic clears carry/overflow, aux held
    do_op(OP_ADD, 1'b0, 16'h000F, 16'h0001, "R5 aux set");
    do_op(OP_LOGIC, 1'b0, 16'h00F0, 16'h0030, "R8 logic");
    // R9 op 11 and no-valid leave status alone
    do_op(OP_NONE, 1'b1, 16'h0000, 16'h0000, "R9 op none");
    do_op(OP_ADD, 1'b1, 16'h0000, 16'h0000, "R9 no valid", 1'b0);
    // R10 control flags
    do_ctl(3'b010, 3'b000, "R10 set ie");
    irq_req = 1'b1; nmi_req = 1'b1;
    @(negedge clk);
    check(irq_accept == 1'b1, "R11 irq with ie", {15'd0, irq_accept}, 16'd1);
    do_ctl(3'b101, 3'b010, "R10 set trap dir clear ie");
    @(negedge clk);
    check(irq_accept == 1'b0, "R11 irq masked", {15'd0, irq_accept}, 16'd0);
    check(nmi_accept == 1'b1, "R11 nmi ungated", {15'd0, nmi_accept}, 16'd1);
    do_ctl(3'b010, 3'b111, "R10 set wins");
    do_op(OP_SUB, 1'b1, 16'h1234, 16'h1234, "R10 status keeps ctrl");
    do_ctl(3'b000, 3'b101, "R10 clear trap dir");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule